// File: doc/BRIEF.md
# Issue-Slot Top-Level Classification Counters

This block watches the issue stage of a four-wide out-of-order core and, once per clock, turns a handful of pipeline observations into raw event increments. Its inputs are the uop counts seen in that cycle (issued, retired, delivered by the frontend, and retired from the microcode sequencer), a backend back-pressure flag, a flag saying that issue is blocked while the machine recovers from a misspeculation, and single-cycle pulses for pipeline clears and retired mispredicted branches. From these it keeps a bank of saturating counters. Software divides them later to split the slot budget into retiring work, wasted speculation, frontend starvation and backend stalls.

Several events are occupancy style: a counter may grow by up to the issue width in a single cycle. Undelivered slots are charged to the frontend only when the backend was willing to accept them. A separate cycle counter compares the undelivered slot count with a programmable threshold and counts whole cycles, not slots, in which starvation reached it. Each counter is selected by index on a combinational read port and the whole bank is zeroed by a clear strobe.

The per-cycle inputs are plain status pins sampled on every rising edge while counting is enabled. No valid/ready handshake exists, because an observation of the pipeline cannot be held back. Back-pressure therefore never applies at this edge.

Top module: `slot_class_counters`

## Requirements
- R1: While `count_en` is high, the cycle counter (index 0) adds 1 and the total-slot counter (index 1) adds ISSUE_W (4) on every rising edge.
- R2: The issued counter (index 2) adds the `issued_uops` value and the retired counter (index 3) adds the `retired_uops` value. Each input above ISSUE_W is taken as ISSUE_W.
- R3: The frontend-bubble counter (index 4) adds ISSUE_W minus the delivered count (delivered clamped to ISSUE_W) only when `be_stall` is low. It adds nothing in a cycle with `be_stall` high.
- R4: The recovery-bubble counter (index 5) adds ISSUE_W in every enabled cycle with `recovering` high, independent of the other inputs.
- R5: The starvation cycle counter (index 6) adds 1 in an enabled cycle with `be_stall` low and the undelivered slot count at least `starve_thr`. It adds 1 at most per cycle.
- R6: The microcode-retired counter (index 7) adds the clamped `ms_retired_uops`. The clear-event counter (index 8) adds 1 per cycle with `machine_clear` high. The mispredict counter (index 9) adds 1 per cycle with `mispred_retired` high.
- R7: While `count_en` is low, no counter changes, whatever the event inputs do.
- R8: A high `clear` zeroes every counter on that edge and takes priority over any increment in the same cycle.
- R9: Each counter is CNT_W bits wide (48 by default) and sticks at 2^CNT_W-1 instead of wrapping.
- R10: `rd_data` shows the counter chosen by `rd_sel` (indices 0 to 9 as listed above) combinationally, so an increment at an edge is readable in the following cycle. An index of 10 or more reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_en | input | 1 | Global enable of all counting |
| clear | input | 1 | Zero all counters, wins over increments |
| issued_uops | input | 3 | Uops issued this cycle |
| retired_uops | input | 3 | Uops retired this cycle |
| delivered_uops | input | 3 | Uops the frontend offered to issue |
| be_stall | input | 1 | Backend back-pressure this cycle |
| recovering | input | 1 | Issue blocked by misspeculation recovery |
| ms_retired_uops | input | 3 | Retired uops from the microcode sequencer |
| machine_clear | input | 1 | Pipeline clear event |
| mispred_retired | input | 1 | Mispredicted branch retired |
| starve_thr | input | 3 | Threshold for the starvation cycle counter |
| rd_sel | input | 4 | Counter index to read |
| rd_data | output | 48 | Selected counter value |

## Verification
A table of mixed cycles is run through the block. It covers full issue, partial delivery, an empty frontend with and without back-pressure, a recovery cycle, and over-range inputs. These show that stalled cycles are not charged to the frontend and that only full starvation counts as a starved cycle. Directed cases then lower the threshold to two, drop the enable while events keep arriving, and raise clear together with activity. A second instance with narrow counters is driven until its slot and issue counters pin at the maximum while its cycle counter has not yet saturated.

// File: rtl/slot_class_pkg.sv
`timescale 1ns/1ps
package slot_class_pkg;
  localparam int NUM_CNT = 10;
  localparam int SEL_W   = $clog2(NUM_CNT);

  typedef enum int {
    CID_CYCLES   = 0,
    CID_SLOTS    = 1,
    CID_ISSUED   = 2,
    CID_RETIRED  = 3,
    CID_FE_BUB   = 4,
    CID_REC_BUB  = 5,
    CID_STARVE   = 6,
    CID_MS_RET   = 7,
    CID_CLEARS   = 8,
    CID_MISPRED  = 9
  } cnt_id_e;
endpackage

// File: rtl/slot_event_gen.sv
`timescale 1ns/1ps
module slot_event_gen
  import slot_class_pkg::*;
#(
  parameter int ISSUE_W = 4,
  parameter int IW      = $clog2(ISSUE_W + 1)
) (
  input  logic                        be_stall,
  input  logic                        recovering,
  input  logic [IW-1:0]               issued_uops,
  input  logic [IW-1:0]               retired_uops,
  input  logic [IW-1:0]               delivered_uops,
  input  logic [IW-1:0]               ms_retired_uops,
  input  logic                        machine_clear,
  input  logic                        mispred_retired,
  input  logic [IW-1:0]               starve_thr,
  output logic [NUM_CNT-1:0][IW-1:0]  inc
);
  localparam logic [IW-1:0] WIDTH_V = IW'(ISSUE_W);

  function automatic logic [IW-1:0] clamp_w(input logic [IW-1:0] v);
    return (v > WIDTH_V) ? WIDTH_V : v;
  endfunction

  logic [IW-1:0] bubbles;

  always_comb begin
    bubbles = WIDTH_V - clamp_w(delivered_uops);
    inc = '0;
    inc[CID_CYCLES]  = IW'(1);
    inc[CID_SLOTS]   = WIDTH_V;
    inc[CID_ISSUED]  = clamp_w(issued_uops);
    inc[CID_RETIRED] = clamp_w(retired_uops);
    inc[CID_FE_BUB]  = be_stall ? '0 : bubbles;
    inc[CID_REC_BUB] = recovering ? WIDTH_V : '0;
    inc[CID_STARVE]  = (!be_stall && (bubbles >= starve_thr)) ? IW'(1) : '0;
    inc[CID_MS_RET]  = clamp_w(ms_retired_uops);
    inc[CID_CLEARS]  = machine_clear ? IW'(1) : '0;
    inc[CID_MISPRED] = mispred_retired ? IW'(1) : '0;
  end

  // R5: a starved cycle never exceeds one count
  always_comb begin
    a_starve_single_r5: assert (inc[CID_STARVE] <= IW'(1));
  end
endmodule

// File: rtl/sat_counter.sv
`timescale 1ns/1ps
module sat_counter #(
  parameter int CNT_W = 48,
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W:0] sum;
  assign sum = {1'b0, cnt} + (CNT_W+1)'(inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (en)      cnt <= sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
  end

  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  p_hold_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(cnt));

  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt >= $past(cnt)));
endmodule

// File: rtl/slot_class_counters.sv
`timescale 1ns/1ps
module slot_class_counters
  import slot_class_pkg::*;
#(
  parameter int ISSUE_W = 4,
  parameter int CNT_W   = 48,
  localparam int IW     = $clog2(ISSUE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              count_en,
  input  logic              clear,
  input  logic [IW-1:0]     issued_uops,
  input  logic [IW-1:0]     retired_uops,
  input  logic [IW-1:0]     delivered_uops,
  input  logic              be_stall,
  input  logic              recovering,
  input  logic [IW-1:0]     ms_retired_uops,
  input  logic              machine_clear,
  input  logic              mispred_retired,
  input  logic [IW-1:0]     starve_thr,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [CNT_W-1:0]  rd_data
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] WIDTH_C  = CNT_W'(ISSUE_W);
  localparam logic [CNT_W-1:0] SLOT_LIM = CNT_MAX / WIDTH_C;

  logic [NUM_CNT-1:0][IW-1:0]    inc;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;

  slot_event_gen #(.ISSUE_W(ISSUE_W), .IW(IW)) u_evgen (
    .be_stall        (be_stall),
    .recovering      (recovering),
    .issued_uops     (issued_uops),
    .retired_uops    (retired_uops),
    .delivered_uops  (delivered_uops),
    .ms_retired_uops (ms_retired_uops),
    .machine_clear   (machine_clear),
    .mispred_retired (mispred_retired),
    .starve_thr      (starve_thr),
    .inc             (inc)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    sat_counter #(.CNT_W(CNT_W), .INC_W(IW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (count_en),
      .clr   (clear),
      .inc   (inc[g]),
      .cnt   (cnt[g])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (rd_sel == SEL_W'(i)) rd_data = cnt[i];
    end
  end

  // R1: slot total tracks width times cycles until saturation
  p_slots_track_cycles_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[CID_CYCLES] <= SLOT_LIM) |-> (cnt[CID_SLOTS] == cnt[CID_CYCLES] * WIDTH_C));

  // R3: a stalled cycle leaves frontend bubbles untouched
  p_stall_no_bubble_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !clear && be_stall) |=> $stable(cnt[CID_FE_BUB]));

  // R4: a recovery cycle charges the whole width
  p_recovery_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !clear && recovering && (cnt[CID_REC_BUB] <= CNT_MAX - WIDTH_C))
    |=> (cnt[CID_REC_BUB] == $past(cnt[CID_REC_BUB]) + WIDTH_C));
endmodule

// File: tb/slot_class_counters_bench.sv
`timescale 1ns/1ps
module slot_class_counters_bench;
  localparam int CLK_P = 10;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic count_en = 1'b0, clear = 1'b0;
  logic [2:0] issued_uops = '0, retired_uops = '0, delivered_uops = '0, ms_retired_uops = '0;
  logic be_stall = 1'b0, recovering = 1'b0, machine_clear = 1'b0, mispred_retired = 1'b0;
  logic [2:0] starve_thr = 3'd4;
  logic [3:0] rd_sel = '0;
  logic [47:0] rd_data;
  logic [3:0]  rd_data_s;

  int total = 0, bad = 0;
  longint exp_c [10];

  always #(CLK_P/2) clk = ~clk;

  slot_class_counters u_slot_class_counters (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .clear(clear),
    .issued_uops(issued_uops), .retired_uops(retired_uops),
    .delivered_uops(delivered_uops), .be_stall(be_stall), .recovering(recovering),
    .ms_retired_uops(ms_retired_uops), .machine_clear(machine_clear),
    .mispred_retired(mispred_retired), .starve_thr(starve_thr),
    .rd_sel(rd_sel), .rd_data(rd_data));

  slot_class_counters #(.CNT_W(4)) u_small (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .clear(clear),
    .issued_uops(issued_uops), .retired_uops(retired_uops),
    .delivered_uops(delivered_uops), .be_stall(be_stall), .recovering(recovering),
    .ms_retired_uops(ms_retired_uops), .machine_clear(machine_clear),
    .mispred_retired(mispred_retired), .starve_thr(starve_thr),
    .rd_sel(rd_sel), .rd_data(rd_data_s));

  // fields: issued, retired, delivered, stall, recovering, ms, clear_ev, mispred
  localparam int NV = 8;
  localparam logic [15:0] VEC [NV] = '{
    {3'd4, 3'd4, 3'd4, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0},
    {3'd2, 3'd1, 3'd2, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0},
    {3'd0, 3'd0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0},
    {3'd0, 3'd0, 3'd0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0},
    {3'd0, 3'd0, 3'd0, 1'b0, 1'b1, 3'd0, 1'b1, 1'b0},
    {3'd7, 3'd6, 3'd7, 1'b0, 1'b0, 3'd5, 1'b0, 1'b1},
    {3'd3, 3'd3, 3'd1, 1'b1, 1'b0, 3'd2, 1'b0, 1'b1},
    {3'd1, 3'd0, 3'd1, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0}
  };

  function automatic longint cl(input logic [2:0] v);
    return (v > 3'd4) ? 4 : longint'(v);
  endfunction

  function automatic string rq(input int idx);
    case (idx)
      0, 1: return "R1";
      2, 3: return "R2";
      4: return "R3";
      5: return "R4";
      6: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic drive(input logic [15:0] v, input logic en, input logic clr);
    @(negedge clk);
    {issued_uops, retired_uops, delivered_uops, be_stall, recovering,
     ms_retired_uops, machine_clear, mispred_retired} = v;
    count_en = en;
    clear = clr;
    @(posedge clk);
    if (clr) begin
      for (int i = 0; i < 10; i++) exp_c[i] = 0;
    end else if (en) begin
      longint bub;
      bub = 4 - cl(v[9:7]);
      exp_c[0] += 1;
      exp_c[1] += W;
      exp_c[2] += cl(v[15:13]);
      exp_c[3] += cl(v[12:10]);
      if (!v[6]) exp_c[4] += bub;
      if (v[5]) exp_c[5] += W;
      if (!v[6] && bub >= longint'(starve_thr)) exp_c[6] += 1;
      exp_c[7] += cl(v[4:2]);
      if (v[1]) exp_c[8] += 1;
      if (v[0]) exp_c[9] += 1;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    count_en = 1'b0;
    clear = 1'b0;
  endtask

  task automatic chk(input logic [3:0] sel, input longint expv, input string tag);
    rd_sel = sel;
    #1;
    total++;
    if (longint'(rd_data) != expv) begin
      bad++;
      $display("FAIL %s sel=%0d got=%0d exp=%0d", tag, sel, rd_data, expv);
    end
  endtask

  task automatic chk_small(input logic [3:0] sel, input longint expv, input string tag);
    rd_sel = sel;
    #1;
    total++;
    if (longint'(rd_data_s) != expv) begin
      bad++;
      $display("FAIL %s small sel=%0d got=%0d exp=%0d", tag, sel, rd_data_s, expv);
    end
  endtask

  task automatic chk_all(input string note);
    for (int i = 0; i < 10; i++) chk(4'(i), exp_c[i], {rq(i), " ", note});
  endtask

  initial begin
    #(CLK_P * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired got=hang exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 10; i++) exp_c[i] = 0;
    repeat (3) @(negedge clk);
    // reset state: all counters zero (R10 read path)
    for (int i = 0; i < 10; i++) chk(4'(i), 0, "R10 reset");
    rst_n = 1'b1;

    // table walk with full-width threshold
    for (int k = 0; k < NV; k++) drive(VEC[k], 1'b1, 1'b0);
    idle();
    chk_all("table");

    // R10: increment readable in the next cycle
    drive(VEC[0], 1'b1, 1'b0);
    idle();
    chk(4'd0, exp_c[0], "R10 next-cycle read");
    chk(4'd10, 0, "R10 out of range");
    chk(4'd15, 0, "R10 out of range");

    // R7: enable low, activity ignored
    drive(VEC[4], 1'b0, 1'b0);
    drive(VEC[5], 1'b0, 1'b0);
    drive(VEC[2], 1'b0, 1'b0);
    idle();
    chk_all("R7 disabled");

    // R8: clear together with enable and activity
    drive(VEC[4], 1'b1, 1'b1);
    idle();
    for (int i = 0; i < 10; i++) chk(4'(i), 0, "R8 clear wins");

    // R5: lower threshold to 2
    starve_thr = 3'd2;
    drive({3'd2, 3'd2, 3'd2, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0}, 1'b1, 1'b0);
    drive({3'd3, 3'd3, 3'd3, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0}, 1'b1, 1'b0);
    drive({3'd0, 3'd0, 3'd0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0}, 1'b1, 1'b0);
    idle();
    chk(4'd6, 1, "R5 threshold two");
    chk(4'd4, 3, "R3 partial bubbles");
    starve_thr = 3'd4;

    // R9: narrow instance saturates
    drive(VEC[0], 1'b1, 1'b1);
    for (int k = 0; k < 6; k++) drive(VEC[0], 1'b1, 1'b0);
    idle();
    chk_small(4'd1, 15, "R9 slots saturate");
    chk_small(4'd2, 15, "R9 issued saturate");
    chk_small(4'd0, 6, "R9 cycles below max");
    chk(4'd1, 24, "R9 wide no saturation");
    drive(VEC[0], 1'b1, 1'b0);
    idle();
    chk_small(4'd1, 15, "R9 stays at max");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule